// File: doc/BRIEF.md
# Serial Link Frame Timing Generator

This block sets the frame rhythm of a slot-based serial audio/control link. It runs on the bit clock that the codec supplies. It keeps a slot counter and a bit-within-slot counter, and it drives the frame sync line back to the codec. The frame is uneven. A 16-bit tag slot comes first, and twelve 20-bit data slots follow it, so one frame is 256 bit clocks long.

A serializer and a deserializer sit next to the block and use its outputs to decide which slot field is active. They need the slot number, the bit position, a one-cycle marker on the last bit of every slot, and a one-cycle marker on the last bit of the frame. All outputs come from registers that change on the rising bit-clock edge. The serializer can therefore change its output on that same edge, and the deserializer can sample on the falling edge.

The reset input is active low. It asserts asynchronously and releases synchronously through a short synchronizer chain.

Top module: `serial_frame_timer`

## Requirements
- R1: While `rst_n` is low, the outputs are held at slot 0, bit 0, with `sync_o`, `slot_last` and `frame_last` all low. This holds asynchronously, without waiting for a clock edge.
- R2: After `rst_n` rises, the position stays at slot 0, bit 0 for two rising edges. It advances to bit 1 on the third rising edge.
- R3: The bit index rises by one per clock. In slot 0 it counts 0..15. In slots 1..12 it counts 0..19. The slot index does not change while the bit index rises.
- R4: After the last bit of a slot, the bit index returns to 0 and the slot index rises by one. After slot 12 the slot index returns to 0, which gives a frame period of 256 clocks.
- R5: `slot_last` is high for exactly one cycle per slot. It is high on bit 15 of slot 0 and on bit 19 of slots 1..12, and low at every other position.
- R6: `frame_last` is high only on bit 19 of slot 12, once every 256 clocks.
- R7: `sync_o` goes high on the last bit of slot 12 and stays high for 16 clocks, through bit 14 of slot 0. It is then low for the other 240 clocks of the frame.
- R8: In the first frame after reset, `sync_o` stays low from slot 0 through bit 18 of slot 12. It first rises on bit 19 of slot 12.
- R9: The slot index never exceeds 12 and the bit index never exceeds 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_o | output | 1 | Frame sync to the codec |
| slot_idx | output | 4 | Current slot number, 0 (tag) to 12 |
| bit_idx | output | 5 | Bit position within the current slot, 0 sent first |
| slot_last | output | 1 | High on the final bit of the current slot |
| frame_last | output | 1 | High on the final bit of the frame |

## Verification
The bound checker tests the local counting rules on every cycle:
- index ranges;
- single-step advance of the bit index;
- the slot step and wrap after a slot end;
- the one-cycle width of the slot marker;
- the rule that the frame marker only appears with a slot end in slot 12;
- the exact positions where sync rises and falls.

Some properties span a whole frame, and only the bench scenarios can show them:
- the 16-high / 240-low sync duty;
- the quiet first frame after reset;
- the two-edge hold as the reset is released;
- the asynchronous clear when reset is reapplied mid-frame.

The bench sweeps several complete frames, cycle by cycle, against positions it computes from the count of elapsed clocks.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int unsigned DEF_TAG_BITS   = 16;
  localparam int unsigned DEF_DATA_BITS  = 20;
  localparam int unsigned DEF_DATA_SLOTS = 12;
  localparam int unsigned DEF_RST_STAGES = 2;

  function automatic int unsigned frame_clocks(int unsigned tag_bits,
                                               int unsigned data_bits,
                                               int unsigned data_slots);
    return tag_bits + data_bits * data_slots;
  endfunction

endpackage

// File: rtl/sft_rst_sync.sv
module sft_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sft_pos_counter.sv
module sft_pos_counter #(
  parameter int unsigned TAG_BITS   = 16,
  parameter int unsigned DATA_BITS  = 20,
  parameter int unsigned DATA_SLOTS = 12,
  parameter int unsigned SLOT_W     = 4,
  parameter int unsigned BIT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              at_end,
  output logic              at_wrap
);

  localparam logic [BIT_W-1:0]  TAG_LAST  = BIT_W'(TAG_BITS - 1);
  localparam logic [BIT_W-1:0]  DATA_LAST = BIT_W'(DATA_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_MAX  = SLOT_W'(DATA_SLOTS);

  logic [SLOT_W-1:0] slot_d;
  logic [BIT_W-1:0]  bit_d;
  logic [BIT_W-1:0]  last_bit;

  always_comb begin
    last_bit = (slot_q == '0) ? TAG_LAST : DATA_LAST;
    at_end   = (bit_q == last_bit);
    at_wrap  = at_end && (slot_q == SLOT_MAX);
    if (at_end) begin
      bit_d  = '0;
      slot_d = at_wrap ? '0 : slot_q + SLOT_W'(1);
    end else begin
      bit_d  = bit_q + BIT_W'(1);
      slot_d = slot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

endmodule

// File: rtl/sft_sync_gen.sv
module sft_sync_gen #(
  parameter int unsigned TAG_BITS   = 16,
  parameter int unsigned DATA_BITS  = 20,
  parameter int unsigned DATA_SLOTS = 12,
  parameter int unsigned SLOT_W     = 4,
  parameter int unsigned BIT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_q,
  input  logic [BIT_W-1:0]  bit_q,
  output logic              sync_q
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(DATA_SLOTS);
  localparam logic [BIT_W-1:0]  SET_BIT  = BIT_W'(DATA_BITS - 2);
  localparam logic [BIT_W-1:0]  CLR_BIT  = BIT_W'(TAG_BITS - 2);

  logic set_pt;
  logic clr_pt;
  logic sync_d;

  // Rise one clock ahead of slot 0; drop after the tag slot's second-to-last bit.
  always_comb begin
    set_pt = (slot_q == SLOT_MAX) && (bit_q == SET_BIT);
    clr_pt = (slot_q == '0) && (bit_q == CLR_BIT);
    if (set_pt) begin
      sync_d = 1'b1;
    end else if (clr_pt) begin
      sync_d = 1'b0;
    end else begin
      sync_d = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
    end
  end

endmodule

// File: rtl/serial_frame_timer.sv
module serial_frame_timer
  import sft_pkg::*;
#(
  parameter int unsigned TAG_BITS   = DEF_TAG_BITS,
  parameter int unsigned DATA_BITS  = DEF_DATA_BITS,
  parameter int unsigned DATA_SLOTS = DEF_DATA_SLOTS,
  parameter int unsigned RST_STAGES = DEF_RST_STAGES,
  localparam int unsigned SLOT_W    = $clog2(DATA_SLOTS + 1),
  localparam int unsigned BIT_W     = $clog2(DATA_BITS)
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  output logic              sync_o,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              slot_last,
  output logic              frame_last
);

  logic rst_n_int;
  logic end_w;
  logic wrap_w;

  sft_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk        (clk_bit),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sft_pos_counter #(
    .TAG_BITS   (TAG_BITS),
    .DATA_BITS  (DATA_BITS),
    .DATA_SLOTS (DATA_SLOTS),
    .SLOT_W     (SLOT_W),
    .BIT_W      (BIT_W)
  ) u_pos (
    .clk     (clk_bit),
    .rst_n   (rst_n_int),
    .slot_q  (slot_idx),
    .bit_q   (bit_idx),
    .at_end  (end_w),
    .at_wrap (wrap_w)
  );

  sft_sync_gen #(
    .TAG_BITS   (TAG_BITS),
    .DATA_BITS  (DATA_BITS),
    .DATA_SLOTS (DATA_SLOTS),
    .SLOT_W     (SLOT_W),
    .BIT_W      (BIT_W)
  ) u_sync (
    .clk    (clk_bit),
    .rst_n  (rst_n_int),
    .slot_q (slot_idx),
    .bit_q  (bit_idx),
    .sync_q (sync_o)
  );

  assign slot_last  = end_w;
  assign frame_last = wrap_w;

endmodule

// File: rtl/sft_timing_chk.sv
module sft_timing_chk #(
  parameter int unsigned TAG_BITS   = 16,
  parameter int unsigned DATA_BITS  = 20,
  parameter int unsigned DATA_SLOTS = 12,
  parameter int unsigned RST_STAGES = 2,
  parameter int unsigned SLOT_W     = 4,
  parameter int unsigned BIT_W      = 5
) (
  input logic              clk_bit,
  input logic              rst_n,
  input logic              sync_o,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [BIT_W-1:0]  bit_idx,
  input logic              slot_last,
  input logic              frame_last
);

  localparam int unsigned HOLD_W = $clog2(RST_STAGES + 1);
  localparam logic [HOLD_W-1:0] HOLD = HOLD_W'(RST_STAGES);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(DATA_SLOTS);

  logic [HOLD_W-1:0] seen_q;
  logic              armed;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (seen_q != HOLD) begin
      seen_q <= seen_q + HOLD_W'(1);
    end
  end

  assign armed = (seen_q == HOLD);

  // R9
  idx_range_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (slot_idx <= SLOT_MAX) && (int'(bit_idx) < DATA_BITS));

  // R3
  bit_step_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (armed && !slot_last) |=>
      (bit_idx == $past(bit_idx) + BIT_W'(1)) && $stable(slot_idx));

  // R4
  slot_step_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (armed && slot_last) |=>
      (bit_idx == '0) &&
      (slot_idx == (($past(slot_idx) == SLOT_MAX) ? '0 : $past(slot_idx) + SLOT_W'(1))));

  // R5
  slot_pulse_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (armed && slot_last) |=> !slot_last);

  // R6
  frame_end_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    frame_last |-> (slot_last && (slot_idx == SLOT_MAX)));

  // R7
  sync_rise_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(sync_o) |-> frame_last);

  // R7
  sync_fall_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $fell(sync_o) |-> ((slot_idx == '0) && (int'(bit_idx) == TAG_BITS - 1)));

endmodule

bind serial_frame_timer sft_timing_chk #(
  .TAG_BITS   (TAG_BITS),
  .DATA_BITS  (DATA_BITS),
  .DATA_SLOTS (DATA_SLOTS),
  .RST_STAGES (RST_STAGES),
  .SLOT_W     (SLOT_W),
  .BIT_W      (BIT_W)
) u_chk (
  .clk_bit    (clk_bit),
  .rst_n      (rst_n),
  .sync_o     (sync_o),
  .slot_idx   (slot_idx),
  .bit_idx    (bit_idx),
  .slot_last  (slot_last),
  .frame_last (frame_last)
);

// File: tb/sim_serial_frame_timer.sv
module sim_serial_frame_timer;

  localparam int CLK_PERIOD = 10;
  localparam int TAG        = 16;
  localparam int DATA       = 20;
  localparam int SLOTS      = 12;
  localparam int FRAME      = TAG + DATA * SLOTS;
  localparam int HOLD       = 2;
  localparam int WATCHDOG   = 50000;

  logic       clk_bit = 1'b0;
  logic       rst_n   = 1'b0;
  logic       sync_o;
  logic [3:0] slot_idx;
  logic [4:0] bit_idx;
  logic       slot_last;
  logic       frame_last;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  serial_frame_timer u0 (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .sync_o     (sync_o),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .slot_last  (slot_last),
    .frame_last (frame_last)
  );

  always #(CLK_PERIOD / 2) clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // k = rising edges since rst_n rose; checks the outputs at the following negedge
  task automatic check_pos(input int k);
    int n, p, e_slot, e_bit, e_sl, e_fl, e_sync;
    bit first;
    n      = (k > HOLD) ? k - HOLD : 0;
    first  = (n < FRAME);
    p      = n % FRAME;
    e_slot = (p < TAG) ? 0 : 1 + (p - TAG) / DATA;
    e_bit  = (p < TAG) ? p : (p - TAG) % DATA;
    e_sl   = (e_bit == ((e_slot == 0) ? TAG - 1 : DATA - 1)) ? 1 : 0;
    e_fl   = (e_sl == 1 && e_slot == SLOTS) ? 1 : 0;
    e_sync = (p == FRAME - 1 || (p <= TAG - 2 && !first)) ? 1 : 0;
    if (k <= HOLD) begin
      check(int'(bit_idx) == 0, "R2 bit held", int'(bit_idx), 0);
    end else begin
      check(int'(bit_idx) == e_bit, "R3 bit", int'(bit_idx), e_bit);
    end
    check(int'(slot_idx) == e_slot, "R4 slot", int'(slot_idx), e_slot);
    check(int'(slot_last) == e_sl, "R5 slot_last", int'(slot_last), e_sl);
    check(int'(frame_last) == e_fl, "R6 frame_last", int'(frame_last), e_fl);
    if (first) begin
      check(int'(sync_o) == e_sync, "R8 first-frame sync", int'(sync_o), e_sync);
    end else begin
      check(int'(sync_o) == e_sync, "R7 sync", int'(sync_o), e_sync);
    end
    check(slot_idx <= 4'd12 && bit_idx <= 5'd19, "R9 range", int'(bit_idx), 19);
  endtask

  task automatic sweep(input int cycles);
    check_pos(0);
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk_bit);
      @(negedge clk_bit);
      check_pos(k);
    end
  endtask

  task automatic check_reset_state(input string req);
    check(slot_idx == '0 && bit_idx == '0, req, int'(slot_idx) * 100 + int'(bit_idx), 0);
    check(!sync_o && !slot_last && !frame_last, req,
          int'({sync_o, slot_last, frame_last}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_bit);
    check_reset_state("R1 reset state");
    rst_n = 1'b1;
    sweep(3 * FRAME + 20);

    // reapply reset mid-frame, away from any edge
    repeat (37) @(negedge clk_bit);
    #1 rst_n = 1'b0;
    #1 check_reset_state("R1 async clear");
    repeat (2) @(negedge clk_bit);
    check_reset_state("R1 held in reset");
    rst_n = 1'b1;
    sweep(FRAME + 40);

    done = 1'b1;
    report();
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
    end
  end

endmodule